// File: doc/BRIEF.md
# Multi-Lane SECDED Read Decoder with Error Statistics

This block sits on a memory read path. Every beat carries several extended-Hamming codewords side by side on one wide bus. For each lane the block computes a Hamming syndrome and the overall parity. It repairs any single flipped bit, flags words that hold two errors, and then packs the repaired payloads back into one wide data word. Results appear one clock after the input beat.

Three plain control ports shape the decode. A decoder enable turns correction and error reporting on or off. A small fault-injection pattern is XORed into the low bits of every lane before decoding, so software can check the error path without a faulty memory. A clear pulse zeroes the two event counters. The counters record how many beats had a corrected error and how many had an uncorrectable one, and each stops at its maximum value instead of wrapping.

Top module: `ecc_rd_decoder`

## Requirements
- R1: Lane g occupies `in_code[g*CW +: CW]`, where CW = DATA_W + r + 1 and r is the smallest count with 2^r >= DATA_W + r + 1. Bit 0 holds even overall parity. Bits at power-of-two indices are check bits. Payload bit i sits at the i-th index, counted upward from 3, that is not a power of two. The payload is returned in `out_data[g*DATA_W +: DATA_W]`. An error-free beat returns the payload unchanged, with both flags low.
- R2: A lane with exactly one flipped bit, at any index including bit 0 and the check bits, has that bit repaired and raises the beat's `out_sec`. It does not raise `out_ded`.
- R3: A lane with two flipped bits (nonzero syndrome, even parity) raises the beat's `out_ded` and not `out_sec` for that lane. The beat flags are the OR over all lanes.
- R4: Outputs are registered. `out_valid`, `out_data`, `out_sec` and `out_ded` reflect the input beat one clock earlier.
- R5: `out_sec` and `out_ded` stay low for a beat whose `in_valid` is low, whatever the codewords hold.
- R6: With `ecc_en` low, no bit is repaired. The payload is taken straight from the codeword after injection, both flags stay low and neither counter moves.
- R7: `inj_mask` is XORed into bits [MASK_W-1:0] of every lane before decoding, whether or not the decoder is enabled.
- R8: `sec_count` and `ded_count` each rise by exactly one for each beat whose matching flag is raised, however many lanes erred. They update on the same edge that registers the flags.
- R9: Each counter holds at 2^CNT_W-1 instead of wrapping.
- R10: `cnt_clear` high at an edge sets both counters to zero. It takes priority over an increment on that same edge.
- R11: Odd overall parity together with a syndrome that points past the last codeword index is reported as DED and not SEC, and no bit is altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat is valid |
| in_code | input | LANES*CW | Concatenated codewords |
| ecc_en | input | 1 | Enables correction and error flags |
| inj_mask | input | MASK_W | Fault pattern XORed into the low bits of each lane |
| cnt_clear | input | 1 | Zeroes both counters |
| out_valid | output | 1 | Registered beat valid |
| out_data | output | LANES*DATA_W | Recovered payloads |
| out_sec | output | 1 | Some lane had a corrected single error |
| out_ded | output | 1 | Some lane had an uncorrectable error |
| sec_count | output | CNT_W | Saturating count of SEC beats |
| ded_count | output | CNT_W | Saturating count of DED beats |

## Verification
The hardest case to reach from the ports is R11: a syndrome that lands beyond the codeword while the parity is odd. No single or double error can produce it. The bench uses an 8-bit payload with 13-bit codewords and injects a deliberate triple fault at indices 1, 4 and 8. That gives syndrome 13 with odd parity. Around this case, the bench sweeps every single-error index and every error pair across all lanes, and covers all 256 payload values. The 4-bit counters are driven into saturation on purpose. Clear is then pulsed on a cycle that would otherwise increment.

// File: rtl/ecc_rd_pkg.sv
package ecc_rd_pkg;

  // Smallest number of Hamming check bits r with 2^r >= dw + r + 1.
  function automatic int check_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Codeword index of payload bit idx: the idx-th non-power-of-two index from 3 upward.
  function automatic int data_slot(input int idx);
    int pos;
    int seen;
    pos  = 0;
    seen = 0;
    for (int p = 3; p < 4096; p++) begin
      if (pos == 0 && (p & (p - 1)) != 0) begin
        if (seen == idx) pos = p;
        seen++;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/ecc_lane_dec.sv
module ecc_lane_dec import ecc_rd_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CW     = 39
) (
  input  logic [CW-1:0]     code,
  input  logic              en,
  output logic [DATA_W-1:0] data,
  output logic              sec,
  output logic              ded
);
  localparam int SYN_W = $clog2(CW);

  function automatic logic [SYN_W-1:0] syndrome_of(input logic [CW-1:0] c);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int p = 1; p < CW; p++)
      if (c[p]) s ^= SYN_W'(p);
    return s;
  endfunction

  logic [SYN_W-1:0] syn;
  logic             odd_par;
  logic             syn_in_range;
  logic             fix_en;
  logic [CW-1:0]    fixed;

  assign syn          = syndrome_of(code);
  assign odd_par      = ^code;
  assign syn_in_range = 32'(syn) < CW;
  assign fix_en       = en && odd_par && (syn != '0) && syn_in_range;

  always_comb begin
    fixed = code;
    if (fix_en) fixed[syn] = ~fixed[syn];
  end

  // R2 / R3 / R11 classification
  assign sec = en && odd_par && syn_in_range;
  assign ded = en && ((syn != '0 && !odd_par) || (odd_par && !syn_in_range));

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam int SLOT = data_slot(i);
    assign data[i] = fixed[SLOT];
  end

endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (clr)                  count <= '0;
    else if (inc && count != TOP)  count <= count + W'(1);
  end

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !clr) |=> count == TOP);

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + W'(1)));

endmodule

// File: rtl/ecc_rd_decoder.sv
module ecc_rd_decoder import ecc_rd_pkg::*; #(
  parameter int  LANES  = 8,
  parameter int  DATA_W = 32,
  parameter int  MASK_W = 8,
  parameter int  CNT_W  = 16,
  localparam int CW     = DATA_W + check_bits(DATA_W) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*CW-1:0]     in_code,
  input  logic                    ecc_en,
  input  logic [MASK_W-1:0]       inj_mask,
  input  logic                    cnt_clear,
  output logic                    out_valid,
  output logic [LANES*DATA_W-1:0] out_data,
  output logic                    out_sec,
  output logic                    out_ded,
  output logic [CNT_W-1:0]        sec_count,
  output logic [CNT_W-1:0]        ded_count
);
  logic [LANES-1:0]        lane_sec;
  logic [LANES-1:0]        lane_ded;
  logic [LANES*DATA_W-1:0] lane_data;
  logic                    beat_sec;
  logic                    beat_ded;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CW-1:0] hit;
    assign hit = in_code[g*CW +: CW] ^ CW'(inj_mask);   // R7 injection

    ecc_lane_dec #(.DATA_W(DATA_W), .CW(CW)) u_dec (
      .code (hit),
      .en   (ecc_en),
      .data (lane_data[g*DATA_W +: DATA_W]),
      .sec  (lane_sec[g]),
      .ded  (lane_ded[g])
    );
  end

  assign beat_sec = in_valid && (|lane_sec);
  assign beat_ded = in_valid && (|lane_ded);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sec   <= 1'b0;
      out_ded   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_sec   <= beat_sec;
      out_ded   <= beat_ded;
      out_data  <= lane_data;
    end
  end

  ecc_sat_counter #(.W(CNT_W)) u_sec_cnt (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clear), .inc (beat_sec), .count (sec_count)
  );

  ecc_sat_counter #(.W(CNT_W)) u_ded_cnt (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clear), .inc (beat_ded), .count (ded_count)
  );

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r5_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_sec && !out_ded));

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_en |=> (!out_sec && !out_ded));

  a_r6_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecc_en && !cnt_clear) |=> ($stable(sec_count) && $stable(ded_count)));

endmodule

// File: tb/ecc_rd_decoder_test.sv
module ecc_rd_decoder_test;
  localparam int LANES = 8;
  localparam int DW    = 8;
  localparam int CW    = 13;
  localparam int MW    = 8;
  localparam int CNW   = 4;
  localparam logic [CNW-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [LANES*CW-1:0] in_code = '0;
  logic ecc_en = 1'b1;
  logic [MW-1:0] inj_mask = '0;
  logic cnt_clear = 1'b0;
  logic out_valid;
  logic [LANES*DW-1:0] out_data;
  logic out_sec, out_ded;
  logic [CNW-1:0] sec_count, ded_count;

  int vectors = 0;
  int misses  = 0;
  logic [CNW-1:0] m_sec = '0, m_ded = '0;
  logic [DW-1:0] ld [LANES];
  logic [CW-1:0] le [LANES];

  always #4 clk = ~clk;   // 125 MHz

  ecc_rd_decoder #(.LANES(LANES), .DATA_W(DW), .MASK_W(MW), .CNT_W(CNW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code), .ecc_en(ecc_en),
    .inj_mask(inj_mask), .cnt_clear(cnt_clear), .out_valid(out_valid), .out_data(out_data),
    .out_sec(out_sec), .out_ded(out_ded), .sec_count(sec_count), .ded_count(ded_count));

  function automatic bit is_p2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0; k = 0;
    for (int p = 3; p < CW; p++) if (!is_p2(p)) begin c[p] = d[k]; k++; end
    for (int b = 1; b < CW; b = b * 2) begin
      logic x; x = 1'b0;
      for (int p = 1; p < CW; p++) if ((p & b) != 0 && p != b) x ^= c[p];
      c[b] = x;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [DW-1:0] extract(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int k;
    d = '0; k = 0;
    for (int p = 3; p < CW; p++) if (!is_p2(p)) begin d[k] = c[p]; k++; end
    return d;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One beat: drive now (at a falling edge), check at the next falling edge.
  task automatic beat(input logic v, input logic en, input logic [MW-1:0] m, input logic clr, input string req);
    logic [LANES*DW-1:0] exp_data;
    logic [LANES*DW-1:0] care;
    logic es, ed;
    es = 1'b0; ed = 1'b0; exp_data = '0; care = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [CW-1:0] flip, cw;
      int n;
      flip = le[l] ^ CW'(m);
      n = $countones(flip);
      cw = encode(ld[l]) ^ flip;
      in_code[l*CW +: CW] = encode(ld[l]) ^ le[l];
      if (!en) begin
        exp_data[l*DW +: DW] = extract(cw); care[l*DW +: DW] = '1;
      end else begin
        if (n <= 1) begin exp_data[l*DW +: DW] = ld[l]; care[l*DW +: DW] = '1; end
        if (n == 1) es = 1'b1;
        if (n >= 2) ed = 1'b1;   // n==3 only used with an out-of-range syndrome (R11)
      end
    end
    es = es & v; ed = ed & v;
    in_valid = v; ecc_en = en; inj_mask = m; cnt_clear = clr;
    if (clr) begin m_sec = '0; m_ded = '0; end
    else begin
      if (es && m_sec != CMAX) m_sec++;
      if (ed && m_ded != CMAX) m_ded++;
    end
    @(negedge clk);
    check(req, "out_valid R4", 64'(out_valid), 64'(v));
    check(req, "out_sec", 64'(out_sec), 64'(es));
    check(req, "out_ded", 64'(out_ded), 64'(ed));
    check(req, "sec_count R8", 64'(sec_count), 64'(m_sec));
    check(req, "ded_count R8", 64'(ded_count), 64'(m_ded));
    if (v) check(req, "out_data", 64'(out_data & care), 64'(exp_data & care));
  endtask

  task automatic clean_lanes();
    for (int l = 0; l < LANES; l++) begin ld[l] = DW'($urandom); le[l] = '0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    clean_lanes();
    repeat (3) @(negedge clk);
    check("R4", "reset out_valid", 64'(out_valid), 64'd0);
    check("R8", "reset sec_count", 64'(sec_count), 64'd0);
    check("R8", "reset ded_count", 64'(ded_count), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all 256 payloads, error free
    for (int b = 0; b < 32; b++) begin
      for (int l = 0; l < LANES; l++) begin ld[l] = DW'(b * LANES + l); le[l] = '0; end
      beat(1'b1, 1'b1, '0, 1'b0, "R1");
    end

    // R2: every single-error index on every lane; counter runs into saturation (R9)
    for (int b = 0; b < 2 * CW; b++) begin
      clean_lanes();
      for (int l = 0; l < LANES; l++) le[l] = CW'(1) << ((b + l) % CW);
      beat(1'b1, 1'b1, '0, 1'b0, "R2_R9");
    end
    check("R9", "sec saturated", 64'(sec_count), 64'(CMAX));

    // R10: clear on a beat that would increment
    clean_lanes(); le[0] = CW'(1) << 5;
    beat(1'b1, 1'b1, '0, 1'b1, "R10");

    // R3: every index pair
    for (int b = 0; b < 78; b++) begin
      int k;
      clean_lanes();
      for (int l = 0; l < LANES; l++) begin
        k = (b + l) % 78;
        for (int a = 0; a < CW; a++)
          for (int c = a + 1; c < CW; c++) begin
            if (k == 0) le[l] = (CW'(1) << a) | (CW'(1) << c);
            k--;
          end
      end
      beat(1'b1, 1'b1, '0, 1'b0, "R3");
    end
    beat(1'b1, 1'b1, '0, 1'b1, "R10");

    // R3: mixed lanes raise both flags
    clean_lanes(); le[2] = CW'(1) << 7; le[5] = CW'(3) << 9;
    beat(1'b1, 1'b1, '0, 1'b0, "R3");

    // R5: corrupt words with valid low
    for (int b = 0; b < 4; b++) begin
      clean_lanes(); le[b] = CW'(1) << 2; le[b+4] = CW'(3);
      beat(1'b0, 1'b1, 8'b0000_0100, 1'b0, "R5");
    end

    // R7 + R8: injected single (bit 2) then double (bits 2,3), four beats each
    beat(1'b1, 1'b1, '0, 1'b1, "R10");
    for (int b = 0; b < 4; b++) begin clean_lanes(); beat(1'b1, 1'b1, 8'b0000_0100, 1'b0, "R7_R8"); end
    check("R8", "sec after four beats", 64'(sec_count), 64'd4);
    beat(1'b1, 1'b1, '0, 1'b1, "R10");
    for (int b = 0; b < 4; b++) begin clean_lanes(); beat(1'b1, 1'b1, 8'b0000_1100, 1'b0, "R7_R8"); end
    check("R8", "ded after four beats", 64'(ded_count), 64'd4);
    check("R8", "sec untouched", 64'(sec_count), 64'd0);

    // R6: decoder disabled with injected faults
    for (int b = 0; b < 4; b++) begin clean_lanes(); beat(1'b1, 1'b0, 8'b1010_1100, 1'b0, "R6"); end
    for (int b = 0; b < 2; b++) begin clean_lanes(); le[1] = CW'(1) << 6; beat(1'b1, 1'b0, '0, 1'b0, "R6"); end

    // R11: triple error at 1,4,8 -> syndrome 13, odd parity
    beat(1'b1, 1'b1, '0, 1'b1, "R10");
    clean_lanes(); le[3] = (CW'(1) << 1) | (CW'(1) << 4) | (CW'(1) << 8);
    beat(1'b1, 1'b1, '0, 1'b0, "R11");
    check("R11", "no sec", 64'(sec_count), 64'd0);

    // Random 0/1/2 errors per lane against the model
    for (int b = 0; b < 300; b++) begin
      clean_lanes();
      for (int l = 0; l < LANES; l++) begin
        int n, a, c;
        n = $urandom % 3;
        a = $urandom % CW;
        c = (a + 1 + ($urandom % (CW - 1))) % CW;
        if (n >= 1) le[l] = CW'(1) << a;
        if (n == 2) le[l] = le[l] | (CW'(1) << c);
      end
      beat(1'b1, 1'b1, '0, (b % 40) == 39, "R2_R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule